// File: doc/BRIEF.md
# Synchronous Pipelined Dual-Port RAM with Burst Address Counters

This block is a true dual-port static memory. Each of its two ports has its own clock, reset and a complete set of registered inputs: address, write data, byte-lane enables, read/write select, two chip selects of opposite polarity, and an address counter control. Either port can reach any word at any time, independently of the other. Read data comes out of a registered stage, one clock after the address register is updated.

Each port keeps its access address in an internal counter. The counter can load the external address, step by one, clear to zero or hold. A burst therefore needs only one external address followed by step commands. The word is split into byte lanes of nine bits, and a per-lane enable gates both writes and read data. The two chip selects allow banking without glue logic. After a port has been deselected, it must see two consecutive selected cycles before it drives valid read data again. The output-enable pin gates the valid flag without a clock and stands in for a tri-state driver.

Default size is 512 words of 36 bits. Setting ADDR_W to 15 gives the full 32K-word array.

Top module: `dpram_sync_pipe`

## Requirements
- R1: While reset is asserted, and after it is released, `x_dout` is zero and `x_dvalid` is low until a qualifying read completes.
- R2: With the port selected, a read whose address is set on rising edge E appears on `x_dout` just after edge E+1, which is the second edge after the pins are presented.
- R3: A write stores only the lanes whose `x_be` bit is high. Lane k covers data bits 9k to 9k+8. Other lanes of the word keep their contents.
- R4: On a read, a lane whose `x_be` bit is low reads as zero on `x_dout`.
- R5: The counter obeys a fixed priority: `x_clr` (clear to zero) over `x_load` (take `x_addr`) over `x_step` (add one) over hold.
- R6: Stepping from the highest address (2^ADDR_W - 1) wraps the counter to zero.
- R7: A port is selected only when `x_ce_n` is low and `x_ce` is high. A deselected cycle neither writes the array nor produces a valid read.
- R8: A read raises `x_dvalid` only if the port was selected both in the cycle the read was presented and in the cycle before it.
- R9: `x_dvalid` is forced low whenever `x_oe_n` is high, in the same cycle and with no clock. `x_dout` is not affected.
- R10: Data written by one port is returned by the other port on a read whose array edge comes after the write edge.
- R11: Both ports operate concurrently and independently on their own address streams.
- R12: `x_rd` high selects a read and low selects a write. A write uses the counter value of that cycle and never raises `x_dvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_addr | input | ADDR_W | Port A external address |
| a_load | input | 1 | Port A counter load strobe |
| a_step | input | 1 | Port A counter advance |
| a_clr | input | 1 | Port A counter clear |
| a_rd | input | 1 | Port A read (1) / write (0) |
| a_be | input | LANES | Port A byte-lane enables |
| a_ce_n | input | 1 | Port A chip select, active low |
| a_ce | input | 1 | Port A chip select, active high |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_din | input | LANES*LANE_W | Port A write data |
| a_dout | output | LANES*LANE_W | Port A read data |
| a_dvalid | output | 1 | Port A output-valid flag |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_addr | input | ADDR_W | Port B external address |
| b_load | input | 1 | Port B counter load strobe |
| b_step | input | 1 | Port B counter advance |
| b_clr | input | 1 | Port B counter clear |
| b_rd | input | 1 | Port B read (1) / write (0) |
| b_be | input | LANES | Port B byte-lane enables |
| b_ce_n | input | 1 | Port B chip select, active low |
| b_ce | input | 1 | Port B chip select, active high |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_din | input | LANES*LANE_W | Port B write data |
| b_dout | output | LANES*LANE_W | Port B read data |
| b_dvalid | output | 1 | Port B output-valid flag |

## Verification
The counter and the control registers take the pins on rising edge E. A write lands in the array on edge E+1, and read data with its valid flag is registered on edge E+1. The valid flag also depends on the select seen on edge E-1, and it responds to the output-enable pin in the same cycle. The bench updates a cycle model at every rising edge, applying the reads before the writes of that edge. It compares both ports at the following falling edge, so each result is sampled in the first half-cycle after the edge that registers it. Lanes written by both ports on the same edge at the same address are marked unknown and masked from comparison.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

   typedef enum logic [1:0] {
      CTR_HOLD  = 2'd0,
      CTR_STEP  = 2'd1,
      CTR_LOAD  = 2'd2,
      CTR_CLEAR = 2'd3
   } ctr_op_e;

   // clear beats load beats step beats hold
   function automatic ctr_op_e ctr_decode(input logic clr, input logic load, input logic step);
      if (clr)       return CTR_CLEAR;
      else if (load) return CTR_LOAD;
      else if (step) return CTR_STEP;
      else           return CTR_HOLD;
   endfunction

endpackage

// File: rtl/dpram_addr_ctr.sv
module dpram_addr_ctr
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   generate
      if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr_w
         $error("dpram_addr_ctr: ADDR_W out of range");
      end
   endgenerate

   ctr_op_e op;
   assign op = ctr_decode(clr, load, step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else begin
         unique case (op)
            CTR_CLEAR: addr <= '0;
            CTR_LOAD:  addr <= addr_in;
            CTR_STEP:  addr <= addr + ONE;  // natural wrap at the top
            default:   addr <= addr;
         endcase
      end
   end

   a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (addr == '0));

   a_r5_load_over_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load) |=> (addr == $past(addr_in)));

   a_r6_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && step && (addr == '1)) |=> (addr == '0));

   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !step) |=> $stable(addr));

endmodule

// File: rtl/dpram_lvt_array.sv
module dpram_lvt_array #(
   parameter int ADDR_W = 9,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk_a,
   input  logic [ADDR_W-1:0]       addr_a,
   input  logic [LANES-1:0]        we_a,
   input  logic [LANES*LANE_W-1:0] din_a,
   output logic [LANES*LANE_W-1:0] rdata_a,
   input  logic                    clk_b,
   input  logic [ADDR_W-1:0]       addr_b,
   input  logic [LANES-1:0]        we_b,
   input  logic [LANES*LANE_W-1:0] din_b,
   output logic [LANES*LANE_W-1:0] rdata_b
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
         $error("dpram_lvt_array: lane geometry must be positive");
      end
   endgenerate

   // One bank per writing port; a pair of tag bits per word and lane
   // records which bank was written last (tags differ -> bank A).
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] bank_a [DEPTH];
      logic [LANE_W-1:0] bank_b [DEPTH];
      logic              tag_a  [DEPTH];
      logic              tag_b  [DEPTH];

      always_ff @(posedge clk_a) begin
         if (we_a[l]) begin
            bank_a[addr_a] <= din_a[l*LANE_W +: LANE_W];
            tag_a[addr_a]  <= ~tag_b[addr_a];
         end
      end

      always_ff @(posedge clk_b) begin
         if (we_b[l]) begin
            bank_b[addr_b] <= din_b[l*LANE_W +: LANE_W];
            tag_b[addr_b]  <= tag_a[addr_b];
         end
      end

      assign rdata_a[l*LANE_W +: LANE_W] =
         (tag_a[addr_a] != tag_b[addr_a]) ? bank_a[addr_a] : bank_b[addr_a];
      assign rdata_b[l*LANE_W +: LANE_W] =
         (tag_a[addr_b] != tag_b[addr_b]) ? bank_a[addr_b] : bank_b[addr_b];
   end

endmodule

// File: rtl/dpram_port.sv
module dpram_port #(
   parameter int ADDR_W = 9,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_in,
   input  logic                    load,
   input  logic                    step,
   input  logic                    clr,
   input  logic                    rd,
   input  logic [LANES-1:0]        be,
   input  logic                    ce_n,
   input  logic                    ce,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_valid,
   output logic [ADDR_W-1:0]       acc_addr,
   output logic [LANES-1:0]        acc_we,
   output logic [LANES*LANE_W-1:0] acc_din,
   input  logic [LANES*LANE_W-1:0] acc_rdata
);

   localparam int DATA_W = LANES * LANE_W;

   logic              pin_sel;
   logic              sel_q, sel_q2, rd_q, rvalid_r;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] din_q, dout_r, rd_masked;

   assign pin_sel = !ce_n && ce;

   dpram_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .load    (load),
      .step    (step),
      .addr_in (addr_in),
      .addr    (acc_addr)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_rmask
      assign rd_masked[l*LANE_W +: LANE_W] = be_q[l] ? acc_rdata[l*LANE_W +: LANE_W] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= 1'b0;
         sel_q2   <= 1'b0;
         rd_q     <= 1'b1;
         be_q     <= '0;
         din_q    <= '0;
         dout_r   <= '0;
         rvalid_r <= 1'b0;
      end else begin
         sel_q  <= pin_sel;
         sel_q2 <= sel_q;
         rd_q   <= rd;
         be_q   <= be;
         din_q  <= din;
         if (sel_q && rd_q) begin
            dout_r   <= rd_masked;
            rvalid_r <= sel_q2;
         end else begin
            rvalid_r <= 1'b0;
         end
      end
   end

   assign acc_we     = (sel_q && !rd_q) ? be_q : '0;
   assign acc_din    = din_q;
   assign dout       = dout_r;
   assign dout_valid = rvalid_r && !oe_n;

   a_r7_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_sel |=> (acc_we == '0) ##1 !rvalid_r);

   a_r8_two_cycle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_r |-> ($past(pin_sel, 2) && $past(pin_sel, 3)));

   a_r12_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !rd_q) |=> !rvalid_r);

endmodule

// File: rtl/dpram_sync_pipe.sv
module dpram_sync_pipe #(
   parameter int ADDR_W = 9,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk_a,
   input  logic                    rst_a_n,
   input  logic [ADDR_W-1:0]       a_addr,
   input  logic                    a_load,
   input  logic                    a_step,
   input  logic                    a_clr,
   input  logic                    a_rd,
   input  logic [LANES-1:0]        a_be,
   input  logic                    a_ce_n,
   input  logic                    a_ce,
   input  logic                    a_oe_n,
   input  logic [LANES*LANE_W-1:0] a_din,
   output logic [LANES*LANE_W-1:0] a_dout,
   output logic                    a_dvalid,
   input  logic                    clk_b,
   input  logic                    rst_b_n,
   input  logic [ADDR_W-1:0]       b_addr,
   input  logic                    b_load,
   input  logic                    b_step,
   input  logic                    b_clr,
   input  logic                    b_rd,
   input  logic [LANES-1:0]        b_be,
   input  logic                    b_ce_n,
   input  logic                    b_ce,
   input  logic                    b_oe_n,
   input  logic [LANES*LANE_W-1:0] b_din,
   output logic [LANES*LANE_W-1:0] b_dout,
   output logic                    b_dvalid
);

   localparam int DATA_W = LANES * LANE_W;

   logic [ADDR_W-1:0] acc_addr_a, acc_addr_b;
   logic [LANES-1:0]  acc_we_a, acc_we_b;
   logic [DATA_W-1:0] acc_din_a, acc_din_b, rdata_a, rdata_b;

   dpram_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_port_a (
      .clk(clk_a), .rst_n(rst_a_n), .addr_in(a_addr), .load(a_load), .step(a_step),
      .clr(a_clr), .rd(a_rd), .be(a_be), .ce_n(a_ce_n), .ce(a_ce), .oe_n(a_oe_n),
      .din(a_din), .dout(a_dout), .dout_valid(a_dvalid),
      .acc_addr(acc_addr_a), .acc_we(acc_we_a), .acc_din(acc_din_a), .acc_rdata(rdata_a)
   );

   dpram_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_port_b (
      .clk(clk_b), .rst_n(rst_b_n), .addr_in(b_addr), .load(b_load), .step(b_step),
      .clr(b_clr), .rd(b_rd), .be(b_be), .ce_n(b_ce_n), .ce(b_ce), .oe_n(b_oe_n),
      .din(b_din), .dout(b_dout), .dout_valid(b_dvalid),
      .acc_addr(acc_addr_b), .acc_we(acc_we_b), .acc_din(acc_din_b), .acc_rdata(rdata_b)
   );

   dpram_lvt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk_a(clk_a), .addr_a(acc_addr_a), .we_a(acc_we_a), .din_a(acc_din_a), .rdata_a(rdata_a),
      .clk_b(clk_b), .addr_b(acc_addr_b), .we_b(acc_we_b), .din_b(acc_din_b), .rdata_b(rdata_b)
   );

endmodule

// File: tb/dpram_sync_pipe_test.sv
module dpram_sync_pipe_test;
   timeunit 1ns; timeprecision 1ps;

   localparam int AW = 9;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0] addr_i [2];
   logic          load_i [2], step_i [2], clr_i [2], rd_i [2];
   logic [3:0]    be_i   [2];
   logic          ce_n_i [2], ce_i [2], oe_n_i [2];
   logic [35:0]   din_i  [2];
   logic [35:0]   dout_o [2];
   logic          dv_o   [2];

   dpram_sync_pipe uut (
      .clk_a(clk), .rst_a_n(rst_n), .a_addr(addr_i[0]), .a_load(load_i[0]), .a_step(step_i[0]),
      .a_clr(clr_i[0]), .a_rd(rd_i[0]), .a_be(be_i[0]), .a_ce_n(ce_n_i[0]), .a_ce(ce_i[0]),
      .a_oe_n(oe_n_i[0]), .a_din(din_i[0]), .a_dout(dout_o[0]), .a_dvalid(dv_o[0]),
      .clk_b(clk), .rst_b_n(rst_n), .b_addr(addr_i[1]), .b_load(load_i[1]), .b_step(step_i[1]),
      .b_clr(clr_i[1]), .b_rd(rd_i[1]), .b_be(be_i[1]), .b_ce_n(ce_n_i[1]), .b_ce(ce_i[1]),
      .b_oe_n(oe_n_i[1]), .b_din(din_i[1]), .b_dout(dout_o[1]), .b_dvalid(dv_o[1])
   );

   int checks = 0, fails = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   // cycle model built from the requirements
   logic [35:0]   ref_mem [DEPTH];
   logic [3:0]    ref_unk [DEPTH];
   logic [AW-1:0] m_cnt [2];
   bit            m_sel_q [2], m_sel_q2 [2], m_rd_q [2], m_rv [2];
   logic [3:0]    m_be_q [2], m_dunk [2];
   logic [35:0]   m_din_q [2], m_dout [2];

   function automatic logic [35:0] lanes2bits(input logic [3:0] m);
      logic [35:0] r;
      for (int l = 0; l < 4; l++) r[l*9 +: 9] = {9{m[l]}};
      return r;
   endfunction

   function automatic logic [35:0] pat(input int i);
      return {27'h5A5A5A5, 9'(i)} ^ (36'(i) * 36'h1234567);
   endfunction

   task automatic model_reset();
      for (int p = 0; p < 2; p++) begin
         m_cnt[p] = '0; m_sel_q[p] = 0; m_sel_q2[p] = 0; m_rd_q[p] = 1; m_rv[p] = 0;
         m_be_q[p] = '0; m_dunk[p] = '0; m_din_q[p] = '0; m_dout[p] = '0;
      end
   endtask

   task automatic model_edge();
      logic [3:0] w [2];
      for (int p = 0; p < 2; p++) begin
         if (m_sel_q[p] && m_rd_q[p]) begin
            m_dout[p] = ref_mem[m_cnt[p]] & lanes2bits(m_be_q[p]);
            m_dunk[p] = ref_unk[m_cnt[p]] & m_be_q[p];
            m_rv[p]   = m_sel_q2[p];
         end else m_rv[p] = 0;
         w[p] = (m_sel_q[p] && !m_rd_q[p]) ? m_be_q[p] : 4'h0;
      end
      for (int p = 0; p < 2; p++)
         for (int l = 0; l < 4; l++)
            if (w[p][l]) begin
               ref_mem[m_cnt[p]][l*9 +: 9] = m_din_q[p][l*9 +: 9];
               ref_unk[m_cnt[p]][l] = 1'b0;
            end
      if (m_cnt[0] == m_cnt[1]) ref_unk[m_cnt[0]] = ref_unk[m_cnt[0]] | (w[0] & w[1]);
      for (int p = 0; p < 2; p++) begin
         m_sel_q2[p] = m_sel_q[p];
         m_sel_q[p]  = !ce_n_i[p] && ce_i[p];
         m_rd_q[p]   = rd_i[p];
         m_be_q[p]   = be_i[p];
         m_din_q[p]  = din_i[p];
         if (clr_i[p])       m_cnt[p] = '0;
         else if (load_i[p]) m_cnt[p] = addr_i[p];
         else if (step_i[p]) m_cnt[p] = m_cnt[p] + 1'b1;
      end
   endtask

   task automatic chk(input int p);
      logic [35:0] um;
      bit ev;
      um = ~lanes2bits(m_dunk[p]);
      ev = m_rv[p] && !oe_n_i[p];
      checks++;
      if (dv_o[p] !== ev) begin
         fails++;
         $display("FAIL %s port%0d dvalid actual=%0b expected=%0b", cur_req, p, dv_o[p], ev);
      end
      checks++;
      if ((dout_o[p] & um) !== (m_dout[p] & um)) begin
         fails++;
         $display("FAIL %s port%0d dout actual=%h expected=%h", cur_req, p, dout_o[p] & um, m_dout[p] & um);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      chk(0); chk(1);
   endtask

   task automatic idle(input int p);
      addr_i[p] = '0; load_i[p] = 0; step_i[p] = 0; clr_i[p] = 0; rd_i[p] = 1;
      be_i[p] = 4'hF; ce_n_i[p] = 0; ce_i[p] = 1; oe_n_i[p] = 0; din_i[p] = '0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL %s watchdog actual=running expected=finished", cur_req);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = '0; ref_unk[i] = 4'hF; end
      idle(0); idle(1);
      model_reset();
      repeat (3) @(negedge clk);
      // R1: outputs cleared in reset
      cur_req = "R1"; chk(0); chk(1);
      rst_n = 1'b1;
      ticks(3);

      // R6 / R12: burst fill of the whole array from port A
      cur_req = "R6";
      load_i[0] = 1; addr_i[0] = '0; rd_i[0] = 0; din_i[0] = pat(0); tick();
      load_i[0] = 0; step_i[0] = 1;
      for (int i = 1; i < DEPTH; i++) begin din_i[0] = pat(i); tick(); end
      idle(0); ticks(2);
      // R6: read burst across the top of the address space
      load_i[0] = 1; addr_i[0] = 9'(DEPTH - 2); tick();
      load_i[0] = 0; step_i[0] = 1; ticks(4);
      idle(0); ticks(2);

      // R2: single load then read, two edges to data
      cur_req = "R2";
      load_i[0] = 1; addr_i[0] = 9'd33; tick();
      idle(0); ticks(2);

      // R5: clear beats load beats step
      cur_req = "R5";
      clr_i[0] = 1; load_i[0] = 1; step_i[0] = 1; addr_i[0] = 9'd100; tick();
      idle(0); ticks(2);
      load_i[0] = 1; step_i[0] = 1; addr_i[0] = 9'd100; tick();
      idle(0); ticks(2);

      // R3 / R12: partial lane write from port B, then full read
      cur_req = "R3";
      load_i[1] = 1; addr_i[1] = 9'd5; rd_i[1] = 0; be_i[1] = 4'b0101; din_i[1] = '1; tick();
      idle(1); ticks(3);
      cur_req = "R12";
      load_i[1] = 1; addr_i[1] = 9'd6; rd_i[1] = 0; din_i[1] = 36'h123456789; tick();
      idle(1); load_i[1] = 1; addr_i[1] = 9'd6; tick();
      idle(1); ticks(2);

      // R4: read with alternate lanes disabled
      cur_req = "R4";
      load_i[1] = 1; addr_i[1] = 9'd5; be_i[1] = 4'b1010; tick();
      load_i[1] = 0; ticks(2);
      idle(1); ticks(1);

      // R7: writes while deselected by either select pin are dropped
      cur_req = "R7";
      ce_n_i[0] = 1; load_i[0] = 1; addr_i[0] = 9'd7; rd_i[0] = 0; din_i[0] = '0; tick();
      ce_n_i[0] = 0; ce_i[0] = 0; addr_i[0] = 9'd8; tick();
      idle(0); ticks(1);
      load_i[0] = 1; addr_i[0] = 9'd7; tick();
      load_i[0] = 0; step_i[0] = 1; tick();
      idle(0); ticks(2);

      // R8: two selected cycles needed before valid returns
      cur_req = "R8";
      ce_n_i[0] = 1; tick();
      ce_n_i[0] = 0; ticks(4);
      ce_i[0] = 0; tick();
      ce_i[0] = 1; ticks(4);

      // R9: output enable gates the valid flag only
      cur_req = "R9";
      oe_n_i[0] = 1; ticks(2);
      oe_n_i[0] = 0; tick();
      @(posedge clk); model_edge(); #1; oe_n_i[0] = 1; @(negedge clk); chk(0); chk(1);
      oe_n_i[0] = 0; ticks(1);

      // R10: write on A, read the same word on B
      cur_req = "R10";
      load_i[0] = 1; addr_i[0] = 9'd20; rd_i[0] = 0; din_i[0] = 36'hFEDCBA987; tick();
      idle(0); load_i[1] = 1; addr_i[1] = 9'd20; tick();
      idle(1); ticks(3);

      // R11: random concurrent traffic on both ports
      cur_req = "R11";
      for (int n = 0; n < 3000; n++) begin
         for (int p = 0; p < 2; p++) begin
            int r;
            r = int'($urandom % 16);
            clr_i[p]  = (r == 0);
            load_i[p] = (r >= 1 && r <= 4);
            step_i[p] = (r >= 8);
            addr_i[p] = 9'($urandom);
            rd_i[p]   = ($urandom % 3) != 0;
            be_i[p]   = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
            ce_n_i[p] = ($urandom % 10) == 0;
            ce_i[p]   = ($urandom % 12) != 0;
            oe_n_i[p] = ($urandom % 8) == 0;
            din_i[p]  = {4'($urandom), 32'($urandom)};
         end
         tick();
      end
      idle(0); idle(1); ticks(3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule